// File: doc/BRIEF.md
# Symmetric-Generator Reed-Solomon Encoder

This block is a systematic RS(255,239) encoder over GF(2^8). Message symbols arrive one per clock on an 8-bit input with a valid/ready handshake and a start-of-block flag. Each accepted symbol is forwarded unchanged to the output and also folded into a 16-stage remainder register. After the 239th symbol of a block, the input stalls for 16 cycles while the remainder is shifted out as the parity symbols. The codeword therefore has 255 symbols: 239 message symbols followed by 16 parity symbols.

The field uses the primitive polynomial x^8+x^4+x^3+x^2+1, and alpha = 0x02. The generator polynomial has the sixteen consecutive roots alpha^120 through alpha^135. These roots form reciprocal pairs, so the coefficient list reads the same forwards and backwards. Because mirrored taps have the same constant, each mirrored pair of taps draws on a single constant multiplier. Only nine products are formed per cycle, and one of them is a multiply by one.

The output is registered. It carries a valid flag and a flag that marks the last symbol of the codeword. It has no backpressure.

Top module: `rs_sym_encoder`

## Requirements
- R1: Following reset, `out_valid` and `out_eop` read 0 and `in_ready` reads 1.
- R2: A symbol accepted at a rising edge (that is, `in_valid` and `in_ready` both high) is driven on `out_data` with `out_valid` high during the cycle that follows that edge.
- R3: Once the 239th symbol of a block is accepted, `in_ready` stays low for exactly 16 cycles and then returns high.
- R4: The 16 cycles after the last message symbol's output carry the coefficients of (m(x)·x^16 mod g(x)), highest degree first, with `out_valid` high. Here m(x) takes the first message symbol as its degree-238 coefficient, and g(x) = (x+α^120)(x+α^121)…(x+α^135) over the field polynomial 0x11D.
- R5: `out_eop` is high on the 16th parity symbol only, and never on a message symbol.
- R6: Each 255-symbol codeword, read with its first symbol as the degree-254 coefficient, evaluates to zero at α^120 through α^135.
- R7: Cycles with `in_valid` low produce `out_valid` low and leave the parity of the block unchanged.
- R8: An accepted symbol with `in_sop` high starts a new block. The earlier partial remainder and symbol count are discarded, and that symbol counts as message symbol 1.
- R9: `in_valid`, `in_sop` and `in_data` have no effect while `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message symbol present |
| in_sop | input | 1 | Marks the first symbol of a block |
| in_data | input | 8 | Message symbol |
| in_ready | output | 1 | Encoder can take a message symbol |
| out_valid | output | 1 | Output symbol present |
| out_data | output | 8 | Codeword symbol |
| out_eop | output | 1 | Marks the last symbol of a codeword |

## Verification
The output flag that ends one codeword and the acceptance of the first symbol of the next block fall in the same cycle when `in_valid` is held high across the parity phase. The same cycle also holds the reload of the remainder from zero. To provoke this, the bench runs back-to-back blocks with no idle cycle between them, sometimes with the next block's start flag already presented while parity is still draining. The cycle model judges each case through three checks: the flag that ends the codeword must land on the 16th parity symbol, the new symbol must be forwarded in the very next cycle, and the new block's parity must still match the division reference and vanish at all sixteen roots.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

    localparam int SYM_W      = 8;
    localparam int CW_SYMS    = 255;
    localparam int MSG_SYMS   = 239;
    localparam int PAR_SYMS   = CW_SYMS - MSG_SYMS;
    localparam int FIRST_ROOT = 120;
    localparam logic [SYM_W-1:0] FIELD_LOW = 8'h1D;   // x^8 + x^4 + x^3 + x^2 + 1

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [PAR_SYMS-1:0][SYM_W-1:0] stage_vec_t;

    typedef enum logic {PH_MSG = 1'b0, PH_PAR = 1'b1} phase_e;

    typedef struct packed {
        logic valid;
        logic eop;
        sym_t data;
    } out_beat_t;

    // Shift-and-add product, reduced by the field polynomial.
    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc = '0;
        sym_t sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_LOW) : (sh << 1);
        end
        return acc;
    endfunction

    function automatic sym_t alpha_pow(input int e);
        sym_t v = 8'h01;
        for (int i = 0; i < e; i++) v = gf_mul(v, 8'h02);
        return v;
    endfunction

    // Ascending coefficients of prod (x + alpha^(FIRST_ROOT+r)).
    function automatic logic [PAR_SYMS:0][SYM_W-1:0] gen_poly();
        logic [PAR_SYMS:0][SYM_W-1:0] g = '0;
        sym_t root;
        g[0] = 8'h01;
        for (int r = 0; r < PAR_SYMS; r++) begin
            root = alpha_pow(FIRST_ROOT + r);
            for (int k = PAR_SYMS; k >= 1; k--) g[k] = g[k-1] ^ gf_mul(g[k], root);
            g[0] = gf_mul(g[0], root);
        end
        return g;
    endfunction

    localparam logic [PAR_SYMS:0][SYM_W-1:0] GEN_COEF = gen_poly();

endpackage

// File: rtl/rs_tap_bank.sv
module rs_tap_bank
    import rs_enc_pkg::*;
#(
    parameter int NPAR = PAR_SYMS
) (
    input  sym_t                         fb,
    output logic [NPAR-1:0][SYM_W-1:0]   taps
);
    localparam int HALF = NPAR / 2;

    // One constant multiplier per mirrored pair; the middle and index 0 stand alone.
    for (genvar k = 0; k <= HALF; k++) begin : g_pair
        sym_t prod;
        assign prod    = gf_mul(fb, GEN_COEF[k]);
        assign taps[k] = prod;
        if (k > 0 && k < NPAR - k) begin : g_mirror
            assign taps[NPAR-k] = prod;
        end
    end

endmodule

// File: rtl/rs_remainder.sv
module rs_remainder
    import rs_enc_pkg::*;
#(
    parameter int NPAR = PAR_SYMS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         shift_en,
    input  logic                         clear,
    input  logic [NPAR-1:0][SYM_W-1:0]   taps,
    output sym_t                         top
);
    logic [NPAR-1:0][SYM_W-1:0] stages;
    logic [NPAR-1:0][SYM_W-1:0] base;

    assign base = clear ? '0 : stages;
    assign top  = stages[NPAR-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else if (shift_en) begin
            stages[0] <= taps[0];
            for (int j = 1; j < NPAR; j++) stages[j] <= base[j-1] ^ taps[j];
        end
    end

    // R4
    flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !clear && taps == '0) |=> stages[0] == '0);

endmodule

// File: rtl/rs_seq.sv
module rs_seq
    import rs_enc_pkg::*;
#(
    parameter int KMSG = MSG_SYMS,
    parameter int NPAR = PAR_SYMS
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sop,
    output logic in_ready,
    output logic accept,
    output logic flush,
    output logic par_last
);
    localparam int CNT_W  = $clog2(KMSG + 1);
    localparam int PCNT_W = $clog2(NPAR + 1);

    phase_e              phase;
    logic [CNT_W-1:0]    msg_cnt;
    logic [PCNT_W-1:0]   par_cnt;
    logic [CNT_W-1:0]    base_cnt;
    logic                last_msg;

    assign in_ready = (phase == PH_MSG);
    assign accept   = in_valid && in_ready;
    assign base_cnt = in_sop ? '0 : msg_cnt;
    assign last_msg = accept && (base_cnt == CNT_W'(KMSG - 1));
    assign flush    = (phase == PH_PAR);
    assign par_last = flush && (par_cnt == PCNT_W'(NPAR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_MSG;
            msg_cnt <= '0;
            par_cnt <= '0;
        end else if (flush) begin
            par_cnt <= par_cnt + 1'b1;
            if (par_last) begin
                phase   <= PH_MSG;
                par_cnt <= '0;
            end
        end else if (accept) begin
            if (last_msg) begin
                phase   <= PH_PAR;
                msg_cnt <= '0;
                par_cnt <= '0;
            end else begin
                msg_cnt <= base_cnt + 1'b1;
            end
        end
    end

    // R3
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        last_msg |=> !in_ready);
    // R3
    ready_return_chk: assert property (@(posedge clk) disable iff (rst)
        par_last |=> in_ready);
    // R8
    restart_count_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && in_sop && !last_msg) |=> msg_cnt == CNT_W'(1));

endmodule

// File: rtl/rs_sym_encoder.sv
module rs_sym_encoder
    import rs_enc_pkg::*;
#(
    parameter int KMSG = MSG_SYMS,
    parameter int NPAR = PAR_SYMS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [SYM_W-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data,
    output logic             out_eop
);
    logic                        accept;
    logic                        flush;
    logic                        par_last;
    sym_t                        top;
    sym_t                        fb;
    logic [NPAR-1:0][SYM_W-1:0]  taps;
    out_beat_t                   beat;

    rs_seq #(.KMSG(KMSG), .NPAR(NPAR)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_ready (in_ready),
        .accept   (accept),
        .flush    (flush),
        .par_last (par_last)
    );

    // Feedback is forced to zero while parity drains; a start flag hides the old remainder.
    assign fb = flush ? '0 : (in_data ^ (in_sop ? '0 : top));

    rs_tap_bank #(.NPAR(NPAR)) u_taps (
        .fb   (fb),
        .taps (taps)
    );

    rs_remainder #(.NPAR(NPAR)) u_rem (
        .clk      (clk),
        .rst      (rst),
        .shift_en (accept || flush),
        .clear    (accept && in_sop),
        .taps     (taps),
        .top      (top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= accept || flush;
            beat.eop   <= par_last;
            beat.data  <= flush ? top : in_data;
        end
    end

    assign out_valid = beat.valid;
    assign out_eop   = beat.eop;
    assign out_data  = beat.data;

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid && !out_eop && out_data == $past(in_data)));
    // R5
    eop_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_eop |-> out_valid);
    // R7
    idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !out_valid);

endmodule

// File: tb/rs_sym_encoder_test.sv
module rs_sym_encoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_eop;

    int checks = 0;
    int fails  = 0;
    string test_tag = "R1";

    always #5 clk = ~clk;

    rs_sym_encoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop)
    );

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
        end
        return p;
    endfunction

    logic [7:0] roots [16];
    logic [7:0] gdesc [17];

    initial begin
        logic [7:0] ga [17];
        logic [7:0] a;
        a = 8'h01;
        for (int i = 0; i < 120; i++) a = fmul(a, 8'h02);
        for (int r = 0; r < 16; r++) begin roots[r] = a; a = fmul(a, 8'h02); end
        for (int k = 0; k < 17; k++) ga[k] = 0;
        ga[0] = 1;
        for (int r = 0; r < 16; r++) begin
            for (int k = 16; k >= 1; k--) ga[k] = ga[k-1] ^ fmul(ga[k], roots[r]);
            ga[0] = fmul(ga[0], roots[r]);
        end
        for (int j = 0; j < 17; j++) gdesc[j] = ga[16-j];
    end

    // Behavioural model: expected registered outputs after each edge.
    logic [7:0] mq[$];
    logic [7:0] pq[$];
    int         par_left = 0;
    logic       exp_valid = 0, exp_eop = 0;
    logic [7:0] exp_data = 0;
    string      exp_field = "R2";

    task automatic long_divide();
        logic [7:0] w [255];
        logic [7:0] c;
        for (int i = 0; i < 255; i++) w[i] = (i < 239) ? mq[i] : 8'h00;
        for (int i = 0; i < 239; i++) begin
            c = w[i];
            for (int j = 1; j <= 16; j++) w[i+j] ^= fmul(c, gdesc[j]);
        end
        pq.delete();
        for (int i = 239; i < 255; i++) pq.push_back(w[i]);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mq.delete(); pq.delete(); par_left = 0;
            exp_valid = 0; exp_eop = 0;
        end else if (par_left > 0) begin
            exp_valid = 1; exp_data = pq.pop_front(); exp_eop = (par_left == 1);
            exp_field = "R4"; par_left--;
        end else if (in_valid) begin
            if (in_sop) mq.delete();
            mq.push_back(in_data);
            exp_valid = 1; exp_data = in_data; exp_eop = 0; exp_field = "R2";
            if (mq.size() == 239) begin long_divide(); mq.delete(); par_left = 16; end
        end else begin
            exp_valid = 0; exp_eop = 0;
        end
    end

    logic [7:0] cw[$];

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", req, test_tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] acc;
        check("R3 ready", {7'd0, in_ready}, {7'd0, par_left == 0});
        check("R7 valid", {7'd0, out_valid}, {7'd0, exp_valid});
        if (exp_valid) begin
            check(exp_field, out_data, exp_data);
            check("R5 eop", {7'd0, out_eop}, {7'd0, exp_eop});
        end
        if (out_valid) begin
            cw.push_back(out_data);
            if (cw.size() > 255) void'(cw.pop_front());
            if (out_eop && cw.size() == 255) begin
                for (int r = 0; r < 16; r++) begin
                    acc = 0;
                    foreach (cw[i]) acc = fmul(acc, roots[r]) ^ cw[i];
                    check("R6 syndrome", acc, 8'h00);
                end
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic put(input logic [7:0] d, input logic s);
        logic took;
        in_valid = 1; in_data = d; in_sop = s;
        do begin took = in_ready; tick(); end while (!took);
    endtask

    task automatic idle(input int n);
        in_valid = 0; in_sop = 0;
        for (int i = 0; i < n; i++) tick();
    endtask

    int lcg = 32'h1357;
    function automatic logic [7:0] rnd();
        lcg = lcg * 1103515245 + 12345;
        return lcg[23:16];
    endfunction

    // kind: 0 random, 1 zeros, 2 all ones
    task automatic block(input int n, input int gap_every, input int kind);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            d = (kind == 1) ? 8'h00 : (kind == 2) ? 8'hFF : rnd();
            put(d, i == 0);
            if (gap_every > 0 && (i % gap_every) == gap_every - 1) idle(2);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        test_tag = "R1";
        check("R1 out_valid", {7'd0, out_valid}, 8'd0);
        check("R1 out_eop", {7'd0, out_eop}, 8'd0);
        check("R1 in_ready", {7'd0, in_ready}, 8'd1);

        test_tag = "R2";
        block(239, 0, 0);
        test_tag = "R3";          // back to back: next start overlaps last parity
        block(239, 0, 0);
        test_tag = "R9";          // start symbol presented while parity drains
        block(239, 0, 2);
        idle(5);
        test_tag = "R7";
        block(239, 5, 0);
        idle(20);
        test_tag = "R8";
        block(60, 0, 0);
        block(239, 0, 0);
        test_tag = "R4";
        block(239, 0, 1);
        idle(30);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog [%s] actual=running expected=done", test_tag);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule